// File: doc/BRIEF.md
# Parallel Port and Dual Timer Register Block

This block is a register-mapped peripheral for an 8-bit processor bus. It uses a 4-bit register address, an 8-bit write path, a combinational 8-bit read path, and one write strobe and one read strobe. It holds two 8-bit output ports. Each port has its own direction mask, and only the bits marked as outputs take the written value. There are two 16-bit down-counters, each loaded through a byte-wide latch, plus an auxiliary control byte and a peripheral control byte. An interrupt flag byte and an interrupt mask byte together drive an active-high interrupt request.

A timer is programmed in two steps. Writing the low byte fills only the low half of its latch. Writing the high byte to the counter address completes the latch, copies all 16 bits into the counter and starts the timer. The timer then counts down once per clock and raises its flag when it runs out. In free-run mode, timer 1 reloads from its latch and keeps counting. Software clears flags by writing ones to them. Mask bits are set or cleared in one write, chosen by the top bit of that write.

Top module: `port_timer_regs`

## Requirements
- R1: A write to port B (address 0x0) stores the data ANDed with the port B direction byte (address 0x2). A write to port A (address 0x1) stores the data ANDed with the port A direction byte (address 0x3). Both direction bytes are plain read/write registers. The stored port values and direction bytes appear on the port outputs one clock after the write.
- R2: A write to address 0x4 or 0x6 replaces only the low byte of the timer 1 latch. The timer 1 counter is left as it was.
- R3: A write to address 0x5 sets the high byte of the timer 1 latch, loads the full 16-bit latch into the timer 1 counter and starts the timer. A write to address 0x7 sets only the latch high byte.
- R4: For timer 2, a write to address 0x8 replaces the latch low byte only. A write to address 0x9 sets the latch high byte, loads the counter and starts the timer.
- R5: Addresses 0x4/0x5 read the timer 1 counter low/high byte. Addresses 0x8/0x9 read the timer 2 counter low/high byte. Addresses 0x6/0x7 read the timer 1 latch low/high byte. Read data is 0 while the read strobe is low.
- R6: A write to the flag register (address 0xD) clears each of flag bits 6..0 that is written as 1 and leaves the other flag bits unchanged.
- R7: A write to the mask register (address 0xE) works as follows. If bit 7 is 1, data bits 6..0 are ORed into the mask. If bit 7 is 0, every mask bit written as 1 is cleared. Reading address 0xE always returns bit 7 as 1.
- R8: After reset, both ports and both direction bytes are 0x00, and both counters and latches are 0. The auxiliary control byte (address 0xB) is 0x20, the peripheral control byte (address 0xC) is 0xB0, the flags are 0x00 and the mask reads 0x90. Addresses 0xB and 0xC are plain read/write bytes.
- R9: Address 0xA always reads 0xFF and ignores writes. Address 0xF reads port A and ignores writes.
- R10: A started timer whose counter is above 1 decrements by one each clock. A started timer whose counter is 0 or 1 sets its flag on that clock edge: bit 6 for timer 1, bit 5 for timer 2. Timer 2 always stops with its counter at 0. Timer 1 stops the same way unless R11 applies.
- R11: When auxiliary control bit 6 is 1, timer 1 reloads its counter from its latch on the edge that sets its flag, and keeps running.
- R12: Flag register bit 7 reads 1, and the interrupt output is high, exactly when some flag among bits 6..0 is set together with its mask bit.
- R13: A timer flag that is set on the same edge as a flag-clear write to that bit stays set. A high-byte counter write on the edge where the timer runs out takes priority over the reload or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| portA | output | 8 | Port A output value |
| portB | output | 8 | Port B output value |
| dirA | output | 8 | Port A direction byte |
| dirB | output | 8 | Port B direction byte |
| irq | output | 1 | Active-high interrupt request |

## Verification
Port writes are tried under several direction masks: all zero, all one, alternating bits, and masks changed between writes. These cases show whether the mask is applied at all and whether it is sampled from the current direction byte. Timers are loaded with counts of 0, 1 and several cycles, in both one-shot and free-run modes. Each counter byte is read every cycle, which separates reload from stop and catches off-by-one expiry. A pseudo-random phase follows, mixing flag-clear writes, mask writes and small timer loads. It forces writes to land on expiry edges, which checks the set-wins and load-wins ordering.

// File: rtl/port_timer_pkg.sv
package port_timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORTB    = 4'h0,
    REG_PORTA    = 4'h1,
    REG_DIRB     = 4'h2,
    REG_DIRA     = 4'h3,
    REG_T1_CNTLO = 4'h4,
    REG_T1_CNTHI = 4'h5,
    REG_T1_LATLO = 4'h6,
    REG_T1_LATHI = 4'h7,
    REG_T2_CNTLO = 4'h8,
    REG_T2_CNTHI = 4'h9,
    REG_SHIFT    = 4'hA,
    REG_AUXCTL   = 4'hB,
    REG_PERCTL   = 4'hC,
    REG_FLAGS    = 4'hD,
    REG_MASK     = 4'hE,
    REG_PORTA_NH = 4'hF
  } regAddr_e;

  typedef struct packed {
    logic wrPortB;
    logic wrPortA;
    logic wrDirB;
    logic wrDirA;
    logic wrT1Lo;
    logic wrT1HiLoad;
    logic wrT1HiLatch;
    logic wrT2Lo;
    logic wrT2HiLoad;
    logic wrAux;
    logic wrPer;
    logic wrFlags;
    logic wrMask;
    logic rdValid;
    regAddr_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import port_timer_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output ctrlStrobe_t       stb
);
  regAddr_e addrE;
  assign addrE = regAddr_e'(regAddr);

  always_comb begin
    stb = '0;
    stb.rdValid = rdEn;
    stb.rdSel = addrE;
    if (wrEn) begin
      unique case (addrE)
        REG_PORTB:    stb.wrPortB = 1'b1;
        REG_PORTA:    stb.wrPortA = 1'b1;
        REG_DIRB:     stb.wrDirB = 1'b1;
        REG_DIRA:     stb.wrDirA = 1'b1;
        REG_T1_CNTLO,
        REG_T1_LATLO: stb.wrT1Lo = 1'b1;
        REG_T1_CNTHI: stb.wrT1HiLoad = 1'b1;
        REG_T1_LATHI: stb.wrT1HiLatch = 1'b1;
        REG_T2_CNTLO: stb.wrT2Lo = 1'b1;
        REG_T2_CNTHI: stb.wrT2HiLoad = 1'b1;
        REG_AUXCTL:   stb.wrAux = 1'b1;
        REG_PERCTL:   stb.wrPer = 1'b1;
        REG_FLAGS:    stb.wrFlags = 1'b1;
        REG_MASK:     stb.wrMask = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptr_timer.sv
module ptr_timer #(
  parameter int BYTE_W = 8,
  parameter bit HAS_FREE_RUN = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrLo,
  input  logic                wrHiLatch,
  input  logic                wrHiLoad,
  input  logic [BYTE_W-1:0]   wrByte,
  input  logic                freeRun,
  output logic [2*BYTE_W-1:0] cnt,
  output logic [2*BYTE_W-1:0] latch,
  output logic                expire
);
  localparam int W = 2 * BYTE_W;
  logic running;
  logic reloadEn;

  assign reloadEn = HAS_FREE_RUN && freeRun;
  assign expire = running && (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      latch <= '0;
      running <= 1'b0;
    end else begin
      if (wrLo) latch[BYTE_W-1:0] <= wrByte;
      if (wrHiLatch || wrHiLoad) latch[W-1:BYTE_W] <= wrByte;
      if (wrHiLoad) begin
        cnt <= {wrByte, latch[BYTE_W-1:0]};
        running <= 1'b1;
      end else if (running) begin
        if (cnt <= W'(1)) begin
          if (reloadEn) begin
            cnt <= latch;
          end else begin
            cnt <= '0;
            running <= 1'b0;
          end
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrHiLoad |=> cnt == {$past(wrByte), $past(latch[BYTE_W-1:0])});
  assert_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (running && !wrHiLoad && cnt > W'(1)) |=> cnt == $past(cnt) - W'(1));
  assert_lo_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && !wrHiLoad && !running) |=> $stable(cnt));
endmodule

// File: rtl/ptr_datapath.sv
module ptr_datapath
  import port_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] portA,
  output logic [DATA_W-1:0] portB,
  output logic [DATA_W-1:0] dirA,
  output logic [DATA_W-1:0] dirB,
  output logic              irq
);
  localparam int NUM_TMR = 2;
  localparam int TMR_W = 2 * DATA_W;
  localparam int FLAG_W = DATA_W - 1;
  localparam int T1_BIT = 6;
  localparam int T2_BIT = 5;

  logic [DATA_W-1:0] auxCtl, perCtl;
  logic [FLAG_W-1:0] flags, mask, flagSet;
  logic [TMR_W-1:0]  tCnt [NUM_TMR];
  logic [TMR_W-1:0]  tLatch [NUM_TMR];
  logic [NUM_TMR-1:0] tExpire, tWrLo, tWrHiLoad, tWrHiLatch;
  logic irqLevel;

  assign tWrLo      = {stb.wrT2Lo, stb.wrT1Lo};
  assign tWrHiLoad  = {stb.wrT2HiLoad, stb.wrT1HiLoad};
  assign tWrHiLatch = {1'b0, stb.wrT1HiLatch};

  generate
    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : gTimer
      ptr_timer #(.BYTE_W(DATA_W), .HAS_FREE_RUN(gi == 0)) timer_i (
        .clk(clk),
        .rstN(rstN),
        .wrLo(tWrLo[gi]),
        .wrHiLatch(tWrHiLatch[gi]),
        .wrHiLoad(tWrHiLoad[gi]),
        .wrByte(wrData),
        .freeRun(auxCtl[6]),
        .cnt(tCnt[gi]),
        .latch(tLatch[gi]),
        .expire(tExpire[gi])
      );
    end
  endgenerate

  always_comb begin
    flagSet = '0;
    flagSet[T1_BIT] = tExpire[0];
    flagSet[T2_BIT] = tExpire[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portA <= '0;
      portB <= '0;
      dirA <= '0;
      dirB <= '0;
      auxCtl <= 8'h20;
      perCtl <= 8'hB0;
      flags <= '0;
      mask <= 7'h10;
    end else begin
      if (stb.wrPortB) portB <= wrData & dirB;
      if (stb.wrPortA) portA <= wrData & dirA;
      if (stb.wrDirB) dirB <= wrData;
      if (stb.wrDirA) dirA <= wrData;
      if (stb.wrAux) auxCtl <= wrData;
      if (stb.wrPer) perCtl <= wrData;
      if (stb.wrFlags) flags <= (flags & ~wrData[FLAG_W-1:0]) | flagSet;
      else flags <= flags | flagSet;
      if (stb.wrMask) begin
        if (wrData[DATA_W-1]) mask <= mask | wrData[FLAG_W-1:0];
        else mask <= mask & ~wrData[FLAG_W-1:0];
      end
    end
  end

  assign irqLevel = |(flags & mask);
  assign irq = irqLevel;

  always_comb begin
    rdData = '0;
    if (stb.rdValid) begin
      unique case (stb.rdSel)
        REG_PORTB:    rdData = portB;
        REG_PORTA,
        REG_PORTA_NH: rdData = portA;
        REG_DIRB:     rdData = dirB;
        REG_DIRA:     rdData = dirA;
        REG_T1_CNTLO: rdData = tCnt[0][DATA_W-1:0];
        REG_T1_CNTHI: rdData = tCnt[0][TMR_W-1:DATA_W];
        REG_T1_LATLO: rdData = tLatch[0][DATA_W-1:0];
        REG_T1_LATHI: rdData = tLatch[0][TMR_W-1:DATA_W];
        REG_T2_CNTLO: rdData = tCnt[1][DATA_W-1:0];
        REG_T2_CNTHI: rdData = tCnt[1][TMR_W-1:DATA_W];
        REG_SHIFT:    rdData = '1;
        REG_AUXCTL:   rdData = auxCtl;
        REG_PERCTL:   rdData = perCtl;
        REG_FLAGS:    rdData = {irqLevel, flags};
        REG_MASK:     rdData = {1'b1, mask};
        default:      rdData = '0;
      endcase
    end
  end

  assert_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrPortB |=> (portB & ~$past(dirB)) == '0);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrFlags && wrData[T2_BIT] && !tExpire[1]) |=> !flags[T2_BIT]);
  assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rstN)
    tExpire[0] |=> flags[T1_BIT]);
  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMask && wrData[DATA_W-1]) |=>
      (mask & $past(wrData[FLAG_W-1:0])) == $past(wrData[FLAG_W-1:0]));
endmodule

// File: rtl/port_timer_regs.sv
module port_timer_regs
  import port_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] portA,
  output logic [DATA_W-1:0] portB,
  output logic [DATA_W-1:0] dirA,
  output logic [DATA_W-1:0] dirB,
  output logic              irq
);
  ctrlStrobe_t stb;

  ptr_ctrl ctrl_i (
    .regAddr(regAddr),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .stb(stb)
  );

  ptr_datapath dp_i (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .wrData(wrData),
    .rdData(rdData),
    .portA(portA),
    .portB(portB),
    .dirA(dirA),
    .dirB(dirB),
    .irq(irq)
  );
endmodule

// File: tb/port_timer_regs_tb.sv
module port_timer_regs_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, portA, portB, dirA, dirB;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // behavioural model state
  int mOrb, mOra, mDdrb, mDdra, mT1c, mT1l, mT2c, mT2l, mAcr, mPcr, mIfr, mIer;
  bit mRun1, mRun2;
  int seed = 32'h1ace;

  always #4 clk = ~clk;

  port_timer_regs dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .portA(portA), .portB(portB),
    .dirA(dirA), .dirB(dirB), .irq(irq)
  );

  task automatic compare(string tag, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mOrb = 0; mOra = 0; mDdrb = 0; mDdra = 0;
    mT1c = 0; mT1l = 0; mT2c = 0; mT2l = 0;
    mAcr = 8'h20; mPcr = 8'hB0; mIfr = 0; mIer = 8'h10;
    mRun1 = 0; mRun2 = 0;
  endtask

  function automatic int modelRead(int a);
    case (a)
      0: return mOrb;
      1, 15: return mOra;
      2: return mDdrb;
      3: return mDdra;
      4: return mT1c % 256;
      5: return mT1c / 256;
      6: return mT1l % 256;
      7: return mT1l / 256;
      8: return mT2c % 256;
      9: return mT2c / 256;
      10: return 8'hFF;
      11: return mAcr;
      12: return mPcr;
      13: return (((mIfr & mIer) != 0) ? 8'h80 : 0) | mIfr;
      default: return 8'h80 | mIer;
    endcase
  endfunction

  function automatic string tagFor(int a);
    if (a <= 3) return "R1";
    if (a <= 9) return "R5";
    if (a == 10 || a == 15) return "R9";
    if (a <= 12) return "R8";
    if (a == 13) return "R12";
    return "R7";
  endfunction

  task automatic modelStep(bit we, int a, int d);
    int n1c, n2c, setF;
    bit n1r, n2r;
    n1c = mT1c; n2c = mT2c; n1r = mRun1; n2r = mRun2; setF = 0;
    if (mRun1) begin
      if (mT1c <= 1) begin
        setF |= 8'h40;
        if ((mAcr & 8'h40) != 0) n1c = mT1l;
        else begin n1c = 0; n1r = 0; end
      end else n1c = mT1c - 1;
    end
    if (mRun2) begin
      if (mT2c <= 1) begin setF |= 8'h20; n2c = 0; n2r = 0; end
      else n2c = mT2c - 1;
    end
    if (we) begin
      case (a)
        0: mOrb = d & mDdrb;
        1: mOra = d & mDdra;
        2: mDdrb = d;
        3: mDdra = d;
        4, 6: mT1l = (mT1l & 16'hFF00) | d;
        5: begin mT1l = (mT1l & 8'hFF) | (d * 256); n1c = mT1l; n1r = 1; end
        7: mT1l = (mT1l & 8'hFF) | (d * 256);
        8: mT2l = (mT2l & 16'hFF00) | d;
        9: begin mT2l = (mT2l & 8'hFF) | (d * 256); n2c = mT2l; n2r = 1; end
        11: mAcr = d;
        12: mPcr = d;
        13: mIfr = mIfr & ~d & 8'h7F;
        14: if ((d & 8'h80) != 0) mIer = mIer | (d & 8'h7F);
            else mIer = mIer & ~d & 8'h7F;
        default: ;
      endcase
    end
    mIfr = mIfr | setF;
    mT1c = n1c; mT2c = n2c; mRun1 = n1r; mRun2 = n2r;
  endtask

  // one bus cycle: drive at negedge, check read, advance, check outputs
  task automatic cyc(bit we, bit re, int a, int d, string tag);
    wrEn = we; rdEn = re; regAddr = 4'(a); wrData = 8'(d);
    #1;
    if (re) compare(tag, rdData, modelRead(a), $sformatf("read addr 0x%0h", a));
    else compare(tag, rdData, 0, "read data idle");
    modelStep(we, a, d);
    @(posedge clk);
    @(negedge clk);
    compare("R1", portA, mOra, "portA");
    compare("R1", portB, mOrb, "portB");
    compare("R1", dirA, mDdra, "dirA");
    compare("R1", dirB, mDdrb, "dirB");
    compare("R12", irq, ((mIfr & mIer) != 0), "irq");
  endtask

  task automatic wr(int a, int d, string tag); cyc(1, 0, a, d, tag); endtask
  task automatic rd(int a, string tag); cyc(0, 1, a, 0, tag); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state
    for (int a = 0; a < 16; a++) rd(a, "R8");
    // R1 masking under several masks
    wr(0, 8'hFF, "R1"); rd(0, "R1");
    wr(2, 8'hA5, "R1"); wr(0, 8'hFF, "R1"); rd(0, "R1");
    wr(3, 8'h0F, "R1"); wr(1, 8'h3C, "R1"); rd(1, "R1");
    wr(3, 8'hFF, "R1"); wr(1, 8'h96, "R1"); rd(1, "R1");
    // R9 ignored writes and fixed read
    wr(10, 8'h12, "R9"); rd(10, "R9");
    wr(15, 8'h00, "R9"); rd(15, "R9"); rd(1, "R9");
    // R8 plain control bytes
    wr(12, 8'h5A, "R8"); rd(12, "R8");
    // R2 low writes touch latch only
    wr(4, 8'h05, "R2"); rd(4, "R2"); rd(6, "R2");
    wr(6, 8'h07, "R2"); rd(4, "R2"); rd(6, "R2");
    // R3 latch-high only, then load
    wr(7, 8'h12, "R3"); rd(7, "R3"); rd(5, "R3");
    wr(7, 8'h00, "R3");
    wr(5, 8'h00, "R3");
    // R10 one-shot countdown of timer 1
    for (int i = 0; i < 10; i++) rd(4, "R10");
    rd(13, "R10");
    // R12 enable bit 6
    wr(14, 8'hC0, "R12"); rd(13, "R12"); rd(14, "R7");
    // R6 clear flag
    wr(13, 8'h40, "R6"); rd(13, "R6");
    // R7 clear mask bits
    wr(14, 8'h10, "R7"); rd(14, "R7");
    // R4 timer 2
    wr(8, 8'h04, "R4"); rd(8, "R4");
    wr(9, 8'h00, "R4");
    wr(14, 8'hA0, "R4");
    for (int i = 0; i < 7; i++) rd(8, "R4");
    rd(13, "R10");
    // counts of 0 and 1
    wr(13, 8'h7F, "R6");
    wr(8, 8'h00, "R10"); wr(9, 8'h00, "R10"); rd(13, "R10"); rd(13, "R10");
    wr(8, 8'h01, "R10"); wr(9, 8'h00, "R10"); rd(9, "R10"); rd(13, "R10");
    // R11 free run
    wr(11, 8'h40, "R11");
    wr(4, 8'h03, "R11"); wr(5, 8'h00, "R11");
    for (int i = 0; i < 12; i++) rd(4, "R11");
    // R13 clear during expiry and reload collisions
    for (int i = 0; i < 8; i++) wr(13, 8'h40, "R13");
    wr(4, 8'h02, "R13"); wr(5, 8'h00, "R13"); rd(4, "R13");
    wr(5, 8'h00, "R13"); rd(4, "R13"); rd(13, "R13");
    // pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      int a, d, k;
      seed = seed * 1103515245 + 12345;
      a = (seed >>> 16) & 15;
      d = (seed >>> 4) & 255;
      k = (seed >>> 24) & 3;
      if (a == 5 || a == 7 || a == 9) d = d & 3;
      if (k == 0) rd(a, tagFor(a));
      else if (k == 1) rd((a + 5) & 15, tagFor((a + 5) & 15));
      else wr(a, d, "R13");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule